// File: doc/BRIEF.md
# Transceiver Enable/Direction Pin Sequencer

This block sits between a time-division-duplex burst scheduler and an RF transceiver whose enable state machine is driven by two pins: a strobe pin that advances the device to its next state and a direction pin that chooses whether the device goes from its idle ALERT state into receive or into transmit. The scheduler raises a receive request or a transmit request for as long as it wants a burst. The sequencer turns those levels into pin activity that the device accepts.

The block keeps its own copy of the device state (ALERT, RX, TX). It moves the direction pin only while that copy reads ALERT, and it holds the direction pin for one full cycle before it fires the enable pin. It drives the enable pin in one of two styles. In level style the enable pin is held high for the whole burst. In pulse style the enable pin gives a single-cycle strobe to enter the burst and another to leave it. The style in force is captured when a burst begins. A cycle in which both requests are high is rejected and reported on an error output.

Top module: `tdd_pin_sequencer`

## Requirements
- R1: While `rstN` is low at a clock edge, the next outputs are `devState`=2'b00 (ALERT), `enablePin`=0, `txnrxPin`=0 and `conflictErr`=0.
- R2: `txnrxPin` never changes on an edge where `devState` was RX (2'b01) or TX (2'b10).
- R3: In ALERT, outside the settle cycle, with exactly one request high and `txnrxPin` different from `txReq`, the next cycle has `txnrxPin`=`txReq`, state still ALERT and `enablePin` low.
- R4: In ALERT, outside the settle cycle, with exactly one request high and `txnrxPin` equal to `txReq`, the next cycle has `devState` RX (if `rxReq`) or TX (if `txReq`) and `enablePin` high.
- R5: For a burst entered with `pulseMode`=0, `enablePin` stays high in every cycle of the burst and is low in the first ALERT cycle after it.
- R6: For a burst entered with `pulseMode`=1, `enablePin` is high only in the first burst cycle and in the first ALERT cycle after the burst.
- R7: In RX or TX, outside the settle cycle, when that burst's own request is low, the next cycle has `devState`=ALERT.
- R8: When `rxReq` and `txReq` are both high, the next cycle has `conflictErr`=1, and the request causes no entry and no direction change; otherwise `conflictErr` is 0 in the next cycle.
- R9: A change of `pulseMode` during a burst does not change how that burst's enable pin behaves.
- R10: The cycle right after any change of `devState` is a settle cycle: no further state change and no direction change happen on its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| rxReq | input | 1 | Receive burst request (level) |
| txReq | input | 1 | Transmit burst request (level) |
| pulseMode | input | 1 | 1 selects pulse style for the enable pin, 0 level style |
| enablePin | output | 1 | Enable strobe to the transceiver |
| txnrxPin | output | 1 | Direction pin: 1 transmit, 0 receive |
| devState | output | 2 | Tracked device state: 00 ALERT, 01 RX, 10 TX |
| conflictErr | output | 1 | High for a cycle after a cycle with both requests high |

## Verification
Every output is a register, so each reaction to a request level sampled on an edge is due in the cycle directly after that edge: a direction update, a burst entry with its enable rise, a burst exit and the conflict flag all land one cycle later, and a full entry that first needs a direction change takes two cycles. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge, and compares all four outputs at the next falling edge, so every comparison looks at the cycle in which the result is due. Scenarios cover both burst styles in both directions, back-to-back bursts, a style switch mid-burst, conflicts in ALERT and in a burst, and a request dropped during the settle cycle.

// File: rtl/tdd_pin_seq_pkg.sv
package tdd_pin_seq_pkg;

  typedef enum logic [1:0] {
    ST_ALERT = 2'b00,
    ST_RX    = 2'b01,
    ST_TX    = 2'b10
  } devState_e;

  typedef struct packed {
    logic dirLoad;
    logic dirVal;
    logic enSet;
    logic enClr;
    logic conflict;
  } pinStrobe_t;

endpackage

// File: rtl/tdd_pin_seq_ctrl.sv
module tdd_pin_seq_ctrl
  import tdd_pin_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxReq,
  input  logic       txReq,
  input  logic       pulseMode,
  input  logic       curTxnrx,
  output pinStrobe_t strb,
  output devState_e  state
);

  devState_e nextState;
  logic pulseLatched, nextPulse;
  logic settle, nextSettle;
  logic bothReq, oneReq, ownReq;

  assign bothReq = rxReq & txReq;
  assign oneReq  = rxReq ^ txReq;
  assign ownReq  = (state == ST_TX) ? txReq : rxReq;

  always_comb begin
    strb          = '0;
    strb.conflict = bothReq;
    nextState     = state;
    nextPulse     = pulseLatched;
    nextSettle    = 1'b0;
    case (state)
      ST_ALERT: begin
        strb.enClr = 1'b1;
        if (oneReq && !settle) begin
          if (curTxnrx != txReq) begin
            strb.dirLoad = 1'b1;
            strb.dirVal  = txReq;
          end else begin
            nextState  = txReq ? ST_TX : ST_RX;
            nextPulse  = pulseMode;
            nextSettle = 1'b1;
            strb.enClr = 1'b0;
            strb.enSet = 1'b1;
          end
        end
      end
      default: begin
        if (!ownReq && !settle) begin
          nextState  = ST_ALERT;
          nextSettle = 1'b1;
          strb.enSet = pulseLatched;
          strb.enClr = !pulseLatched;
        end else begin
          strb.enClr = pulseLatched;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_ALERT;
      pulseLatched <= 1'b0;
      settle       <= 1'b0;
    end else begin
      state        <= nextState;
      pulseLatched <= nextPulse;
      settle       <= nextSettle;
    end
  end

endmodule

// File: rtl/tdd_pin_seq_dp.sv
module tdd_pin_seq_dp
  import tdd_pin_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pinStrobe_t strb,
  output logic       enableOut,
  output logic       txnrxOut,
  output logic       conflictOut
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableOut   <= 1'b0;
      txnrxOut    <= 1'b0;
      conflictOut <= 1'b0;
    end else begin
      if (strb.enSet)        enableOut <= 1'b1;
      else if (strb.enClr)   enableOut <= 1'b0;
      if (strb.dirLoad)      txnrxOut  <= strb.dirVal;
      conflictOut <= strb.conflict;
    end
  end

endmodule

// File: rtl/tdd_pin_sequencer.sv
module tdd_pin_sequencer
  import tdd_pin_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxReq,
  input  logic       txReq,
  input  logic       pulseMode,
  output logic       enablePin,
  output logic       txnrxPin,
  output logic [1:0] devState,
  output logic       conflictErr
);

  pinStrobe_t strb;
  devState_e  stateQ;

  tdd_pin_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxReq(rxReq), .txReq(txReq),
    .pulseMode(pulseMode), .curTxnrx(txnrxPin), .strb(strb), .state(stateQ)
  );

  tdd_pin_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .enableOut(enablePin), .txnrxOut(txnrxPin), .conflictOut(conflictErr)
  );

  assign devState = stateQ;

endmodule

// File: rtl/tdd_pin_sequencer_chk.sv
module tdd_pin_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxReq,
  input logic       txReq,
  input logic       enablePin,
  input logic       txnrxPin,
  input logic [1:0] devState,
  input logic       conflictErr
);

  a_r2_dir_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (devState != 2'b00) |=> $stable(txnrxPin));

  a_r4_enable_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    (devState != 2'b00 && $past(devState) == 2'b00) |-> enablePin);

  a_r8_conflict_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rxReq && txReq) |=> conflictErr);

  a_r8_conflict_no_dir: assert property (@(posedge clk) disable iff (!rstN)
    (rxReq && txReq) |=> $stable(txnrxPin));

  a_r10_settle: assert property (@(posedge clk) disable iff (!rstN)
    (devState != $past(devState)) |=> $stable(devState));

endmodule

bind tdd_pin_sequencer tdd_pin_sequencer_chk u_chk (
  .clk(clk), .rstN(rstN), .rxReq(rxReq), .txReq(txReq),
  .enablePin(enablePin), .txnrxPin(txnrxPin), .devState(devState),
  .conflictErr(conflictErr)
);

// File: tb/tdd_pin_sequencer_bench.sv
module tdd_pin_sequencer_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxReq = 1'b0, txReq = 1'b0, pulseMode = 1'b0;
  logic enablePin, txnrxPin, conflictErr;
  logic [1:0] devState;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  // model state
  int mState = 0, mEn = 0, mDir = 0, mConf = 0, mPulse = 0, mSettle = 0;

  always #10 clk = ~clk;

  tdd_pin_sequencer u_tdd_pin_sequencer (
    .clk(clk), .rstN(rstN), .rxReq(rxReq), .txReq(txReq), .pulseMode(pulseMode),
    .enablePin(enablePin), .txnrxPin(txnrxPin), .devState(devState),
    .conflictErr(conflictErr)
  );

  // behavioural model: ALERT=0, RX=1, TX=2
  always @(posedge clk) begin
    int r, t, nSettle;
    r = rxReq; t = txReq;
    if (!rstN) begin
      mState = 0; mEn = 0; mDir = 0; mConf = 0; mPulse = 0; mSettle = 0;
    end else begin
      nSettle = 0;
      mConf = (r && t) ? 1 : 0;
      if (mState == 0) begin
        if ((r + t) == 1 && !mSettle) begin
          if (mDir != t) begin
            mDir = t; mEn = 0;
          end else begin
            mState = t ? 2 : 1; mEn = 1; mPulse = pulseMode; nSettle = 1;
          end
        end else mEn = 0;
      end else begin
        if (((mState == 1) ? r : t) == 0 && !mSettle) begin
          mState = 0; nSettle = 1; mEn = mPulse ? 1 : 0;
        end else if (mPulse) mEn = 0;
      end
      mSettle = nSettle;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic t, input logic pm, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp("devState", int'(devState), mState);
      cmp("enablePin", int'(enablePin), mEn);
      cmp("txnrxPin", int'(txnrxPin), mDir);
      cmp("conflictErr", int'(conflictErr), mConf);
      rxReq = r; txReq = t; pulseMode = pm;
    end
  endtask

  initial begin
    fork
      begin
        #4000000;
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    tag = "R1"; step(0, 0, 0, 3);
    rstN = 1'b1; step(0, 0, 0, 2);
    tag = "R4_R5"; step(1, 0, 0, 8);     // level RX burst, TXNRX already low
    tag = "R7_R5"; step(0, 0, 0, 4);
    tag = "R3_R2"; step(0, 1, 0, 8);     // level TX burst needs direction change
    step(0, 0, 0, 4);
    tag = "R6"; step(0, 1, 1, 8);        // pulse TX burst
    step(0, 0, 1, 4);
    tag = "R6_R3"; step(1, 0, 1, 8);     // pulse RX burst after direction flip
    step(0, 0, 1, 4);
    tag = "R8"; step(1, 1, 0, 3);        // conflict in ALERT
    step(0, 0, 0, 2);
    step(1, 0, 0, 4);
    step(1, 1, 0, 3);                    // conflict inside RX burst
    step(0, 1, 0, 6);                    // own drops, other rises same cycle
    step(0, 0, 0, 4);
    tag = "R9"; step(1, 0, 1, 3);        // pulse burst, switch to level mid-burst
    step(1, 0, 0, 4);
    step(0, 0, 0, 4);
    step(0, 1, 0, 4);                    // level burst, switch to pulse mid-burst
    step(0, 1, 1, 4);
    step(0, 0, 1, 4);
    tag = "R10"; step(0, 1, 0, 1);       // drop request during settle cycle
    step(0, 0, 0, 1);
    step(0, 0, 0, 4);
    step(0, 1, 1, 1);
    step(0, 0, 1, 6);
    step(1, 0, 0, 3);                    // back-to-back after exit
    step(0, 1, 0, 1);
    step(0, 1, 0, 8);
    step(0, 0, 0, 4);
    tag = "R1"; rstN = 1'b0; step(0, 1, 0, 3);
    rstN = 1'b1; step(0, 0, 0, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule